// File: doc/BRIEF.md
# GPIO Controller with Atomic Set/Clear Output Latches

This block is a memory-mapped general-purpose I/O controller for twenty pins on a simple 64-bit register bus. The bus has one address, a write strobe with write data, and a read strobe with read data. Each access takes a single cycle. A read returns its data on the clock edge that samples the strobe.

Software drives the output latches only through two write-only mask registers. One sets latch bits and the other clears them, so several pins can change at once without a read-modify-write. Every pin has its own configuration word. Bit 0 of that word is the output enable, and the other bits are plain storage.

The configuration words sit in two windows. Pins 0 to 15 sit at a stride of 8 from offset 0. Pins 16 to 19 start again at 0x100. The pin inputs are synchronised by two flops before software can read them.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is asserted and after it is released, all output latches are 0, all output enables are 0 and `rd_data` is 0. Every configuration word reads back as 0 after reset.
- R2: A read at offset 0x80 returns the synchronised level of pin n in bit n. Bits 20 to 63 of the returned word are 0.
- R3: A write at offset 0x88 sets the latch of every pin whose bit in `wr_data[19:0]` is 1. Latches of the other pins keep their values.
- R4: A write at offset 0x90 clears the latch of every pin whose bit in `wr_data[19:0]` is 1. Latches of the other pins keep their values.
- R5: The configuration word of pin n is at offset 8*n for n below 16, and at 0x100 + 8*(n-16) for n from 16 to 19. Bit 0 of that word drives `pin_oe[n]`, and writing it as 0 makes the pin an input.
- R6: Configuration bits 1 to 63 are stored and read back as written. They affect neither `pin_oe` nor `pin_out`.
- R7: A latch keeps its value while its pin's output enable is 0. When the enable rises, `pin_out` already presents the held value.
- R8: A change on `pin_in` shows up in a data-register read issued two clock edges after the change is first sampled, and not earlier.
- R9: The following reads return 0: reads of 0x88, 0x90, any unmapped or misaligned offset, and mask bits 20 to 63. Writes to those offsets, writes to 0x80, and mask bits 20 to 63 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 64 | Read data, updated on the edge that samples `rd_en` |
| pin_in | input | 20 | Raw pin input levels |
| pin_out | output | 20 | Output latch values |
| pin_oe | output | 20 | Per-pin output enables |

## Verification
A corrupted latch bit shows up on `pin_out` on the very edge after the faulty write, because the latches drive the port directly. A wrong decode of the split configuration window shows up on `pin_oe` at once for the wrong pin, and on the next read of that pin's word. A fault in the input synchroniser is visible only through reads of the data register. So the bench steps a pin change against reads one, two and three edges later to pin down the exact latency.

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl #(
  parameter int NPINS     = 20,
  parameter int AW        = 12,
  parameter int DW        = 64,
  parameter int LOW_PINS  = 16,
  parameter int STRIDE    = 8,
  parameter int HIGH_BASE = 'h100,
  parameter int DATA_OFF  = 'h080,
  parameter int SET_OFF   = 'h088,
  parameter int CLR_OFF   = 'h090
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);

  localparam logic [AW-1:0] A_DATA = AW'(DATA_OFF);
  localparam logic [AW-1:0] A_SET  = AW'(SET_OFF);
  localparam logic [AW-1:0] A_CLR  = AW'(CLR_OFF);

  function automatic logic [AW-1:0] cfg_addr(input int n);
    return (n < LOW_PINS) ? AW'(STRIDE * n) : AW'(HIGH_BASE + STRIDE * (n - LOW_PINS));
  endfunction

  logic [NPINS-1:0]    out_q, sync1_q, sync2_q, cfg_sel;
  logic [NPINS*DW-1:0] cfg_flat;
  logic [DW-1:0]       rd_mux, rd_q;

  wire             set_hit = wr_en && (addr == A_SET);
  wire             clr_hit = wr_en && (addr == A_CLR);
  wire [NPINS-1:0] mask    = wr_data[NPINS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (set_hit)      out_q <= out_q | mask;
      else if (clr_hit) out_q <= out_q & ~mask;
    end
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic [DW-1:0] cfg_q;
    assign cfg_sel[n] = (addr == cfg_addr(n));
    always_ff @(posedge clk) begin
      if (!rst_n)                  cfg_q <= '0;
      else if (wr_en && cfg_sel[n]) cfg_q <= wr_data;
    end
    assign cfg_flat[n*DW +: DW] = cfg_q;
    assign pin_oe[n]            = cfg_q[0];
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_DATA) rd_mux = DW'(sync2_q);
    for (int n = 0; n < NPINS; n++)
      if (cfg_sel[n]) rd_mux = rd_mux | cfg_flat[n*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data = rd_q;
  assign pin_out = out_q;

  logic [1:0] up_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)              up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (pin_out == '0 && pin_oe == '0 && rd_data == '0));

  p_data_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_DATA) |=> rd_data[DW-1:NPINS] == '0);

  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=> (pin_out & $past(wr_data[NPINS-1:0])) == $past(wr_data[NPINS-1:0]));

  p_set_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=> (pin_out & ~$past(wr_data[NPINS-1:0])) == ($past(pin_out) & ~$past(wr_data[NPINS-1:0])));

  p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> (pin_out & $past(wr_data[NPINS-1:0])) == '0);

  p_clr_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> (pin_out & ~$past(wr_data[NPINS-1:0])) == ($past(pin_out) & ~$past(wr_data[NPINS-1:0])));

  p_oe_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_oe));

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_SET || addr == A_CLR)) |=> $stable(pin_out));

  p_sync_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_DATA && up_cnt == 2'd3) |=> rd_data[NPINS-1:0] == $past(pin_in, 3));

  p_wo_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == A_SET || addr == A_CLR || addr[2:0] != 3'd0)) |=> rd_data == '0);

  p_data_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DATA) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/sim_gpio_setclr_ctrl.sv
module sim_gpio_setclr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [63:0] rd_data;
  logic [19:0] pin_in = '0;
  logic [19:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;

  always #10ns clk = ~clk;

  gpio_setclr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] a;
    logic [63:0] d;
    logic [19:0] eout;
    logic [19:0] eoe;
    logic [63:0] erd;
    logic [3:0]  req;
  } vec_t;

  localparam logic [19:0] PIN_PAT = 20'h5A5C3;
  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 12'h088, 64'hFFFF_FFFF_FFF0_0013, 20'h00013, 20'h00000, 64'h0, 4'd3},   // R3, R9 upper mask
    '{2'd1, 12'h088, 64'h0000_0000_0000_0300, 20'h00313, 20'h00000, 64'h0, 4'd3},   // R3
    '{2'd1, 12'h090, 64'h0000_0000_0000_0012, 20'h00301, 20'h00000, 64'h0, 4'd4},   // R4
    '{2'd1, 12'h090, 64'hFFFF_FFFF_FFF0_0000, 20'h00301, 20'h00000, 64'h0, 4'd9},   // R9
    '{2'd1, 12'h000, 64'h1,                   20'h00301, 20'h00001, 64'h0, 4'd5},   // R5 pin 0
    '{2'd1, 12'h078, 64'h1,                   20'h00301, 20'h08001, 64'h0, 4'd5},   // R5 pin 15
    '{2'd1, 12'h100, 64'h1,                   20'h00301, 20'h18001, 64'h0, 4'd5},   // R5 pin 16
    '{2'd1, 12'h118, 64'h1,                   20'h00301, 20'h98001, 64'h0, 4'd5},   // R5 pin 19
    '{2'd1, 12'h080, 64'hFFFF_FFFF_FFFF_FFFF, 20'h00301, 20'h98001, 64'h0, 4'd9},   // R9
    '{2'd1, 12'h120, 64'h1,                   20'h00301, 20'h98001, 64'h0, 4'd9},   // R9
    '{2'd1, 12'h0F8, 64'h1,                   20'h00301, 20'h98001, 64'h0, 4'd9},   // R9
    '{2'd1, 12'h008, 64'hDEAD_BEEF_0000_00F0, 20'h00301, 20'h98001, 64'h0, 4'd6},   // R6
    '{2'd2, 12'h008, 64'h0, 20'h00301, 20'h98001, 64'hDEAD_BEEF_0000_00F0, 4'd6},   // R6
    '{2'd2, 12'h118, 64'h0, 20'h00301, 20'h98001, 64'h1, 4'd5},                     // R5
    '{2'd2, 12'h088, 64'h0, 20'h00301, 20'h98001, 64'h0, 4'd9},                     // R9
    '{2'd2, 12'h090, 64'h0, 20'h00301, 20'h98001, 64'h0, 4'd9},                     // R9
    '{2'd2, 12'h0F8, 64'h0, 20'h00301, 20'h98001, 64'h0, 4'd9},                     // R9
    '{2'd2, 12'h080, 64'h0, 20'h00301, 20'h98001, 64'(PIN_PAT), 4'd2},              // R2
    '{2'd1, 12'h000, 64'h0,                   20'h00301, 20'h98000, 64'h0, 4'd5},   // R5 to input
    '{2'd1, 12'h118, 64'h2,                   20'h00301, 20'h18000, 64'h0, 4'd6},   // R6
    '{2'd2, 12'h118, 64'h0, 20'h00301, 20'h18000, 64'h2, 4'd6},                     // R6
    '{2'd2, 12'h104, 64'h0, 20'h00301, 20'h18000, 64'h0, 4'd9}                      // R9
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    #(20ns * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pin_in = PIN_PAT;
    repeat (3) @(negedge clk);
    check("R1 out in reset", 64'(pin_out), 64'h0);
    check("R1 oe in reset", 64'(pin_oe), 64'h0);
    check("R1 rd in reset", rd_data, 64'h0);
    rst_n = 1'b1;
    rd(12'h100);
    check("R1 cfg after reset", rd_data, 64'h0);
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].op == 2'd1) wr(TBL[i].a, TBL[i].d);
      else                   rd(TBL[i].a);
      check($sformatf("R%0d row %0d out", TBL[i].req, i), 64'(pin_out), 64'(TBL[i].eout));
      check($sformatf("R%0d row %0d oe", TBL[i].req, i), 64'(pin_oe), 64'(TBL[i].eoe));
      if (TBL[i].op == 2'd2)
        check($sformatf("R%0d row %0d rd", TBL[i].req, i), rd_data, TBL[i].erd);
    end

    wr(12'h088, 64'h4);
    check("R7 latch set while input", 64'(pin_out), 64'h00305);
    check("R7 oe stays low", 64'(pin_oe), 64'h18000);
    wr(12'h040, 64'h1);
    check("R7 oe rises on pin 8", 64'(pin_oe), 64'h18100);
    check("R7 held value presented", 64'(pin_out), 64'h00305);
    wr(12'h090, 64'h100);
    check("R4 clear driven pin", 64'(pin_out), 64'h00205);

    @(negedge clk); pin_in = 20'hFFFFF; addr = 12'h080; rd_en = 1'b1;
    @(negedge clk); check("R8 read one edge on", rd_data, 64'(PIN_PAT));
    @(negedge clk); check("R8 read two edges on", rd_data, 64'(PIN_PAT));
    @(negedge clk); check("R8 read three edges on", rd_data, 64'hFFFFF);
    rd_en = 1'b0;

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 out after late reset", 64'(pin_out), 64'h0);
    check("R1 oe after late reset", 64'(pin_oe), 64'h0);
    check("R1 rd after late reset", rd_data, 64'h0);
    rst_n = 1'b1;
    rd(12'h040);
    check("R1 cfg cleared", rd_data, 64'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule